// File: doc/BRIEF.md
# Two-Step Configuration Write Guard

This block sits in front of a timer's configuration storage and decides which register writes may reach it. It keeps a two-bit lock state. A single write of the "set all" code arms both lock bits at once. Disarming takes two separate writes, each carrying its own clear code and each clearing a different bit. While either bit is still set, the guard reports the block as locked and drops every write aimed at the control, configuration or match registers. Writes to the interrupt request, interrupt set and interrupt mask registers always pass.

Software reaches the block through a single write port. A valid strobe carries a target select and a data word. When the target is the lock register, data bits [1:0] carry the lock code. For every other target, the guard passes the data on with a one-hot write-enable vector, one cycle later, unless the lock blocks that write. Blocked writes are dropped without any error response.

Top module: `cfg_write_guard`

## Requirements
- R1: After synchronous reset, lock_bits is 0, locked is 0 and out_we is all zero.
- R2: A write to the lock target (wr_target = 0) with data[1:0] = 3 sets both lock bits, seen on lock_bits one cycle later.
- R3: A lock-target write with data[1:0] = 1 clears lock bit 0 and leaves bit 1 unchanged.
- R4: A lock-target write with data[1:0] = 2 clears lock bit 1 and leaves bit 0 unchanged.
- R5: A lock-target write with data[1:0] = 0, and any write to another target, leaves lock_bits unchanged.
- R6: locked is 1 exactly when at least one lock bit is set, and it updates in the same cycle as lock_bits.
- R7: While locked, a write to control (target 1), configuration (target 2) or match (target 3) produces no out_we bit.
- R8: A write to interrupt request (4), interrupt set (5) or interrupt mask (6) always produces out_we with only that target's bit set, one cycle later, whatever the lock state.
- R9: While unlocked, a write to target 1, 2 or 3 produces out_we with only that target's bit set and out_data equal to wr_data, one cycle later.
- R10: Writes to the lock target, or to an unused target number (7), never produce an out_we bit.
- R11: The two clearing writes may come in either order, with other accesses between them. The block unlocks only after both have been written.
- R12: Whether a protected write is blocked depends on the lock state before that write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_target | input | 3 | Register select: 0 lock, 1 control, 2 config, 3 match, 4 irq request, 5 irq set, 6 irq mask |
| wr_data | input | 32 | Write data; bits [1:0] are the lock code for target 0 |
| lock_bits | output | 2 | Current lock state |
| locked | output | 1 | High while any lock bit is set |
| out_we | output | 7 | Registered one-hot write enable per target |
| out_data | output | 32 | Registered write data for out_we |

## Verification
The bench applies directed sequences for set-then-clear in both clear orders, including clears interleaved with interrupt and protected writes. These separate a guard that needs both clears from one that opens after either clear. Code 0 and repeated clears check that the state holds and that the clears are idempotent. A long run of random targets, codes and data mixes every target with every lock state, so that gating by the wrong bit or the wrong target class shows up as a difference from the bench model. Unused target 7 and lock-target writes check that out_we stays quiet.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam int TGT_W   = 3;
  localparam int NUM_TGT = 7;

  typedef enum logic [TGT_W-1:0] {
    TGT_LOCK  = 3'd0,
    TGT_CTRL  = 3'd1,
    TGT_CFG   = 3'd2,
    TGT_MATCH = 3'd3,
    TGT_IRQ   = 3'd4,
    TGT_ISET  = 3'd5,
    TGT_IMASK = 3'd6
  } tgt_e;

  localparam logic [1:0] CODE_HOLD   = 2'd0;
  localparam logic [1:0] CODE_CLR0   = 2'd1;
  localparam logic [1:0] CODE_CLR1   = 2'd2;
  localparam logic [1:0] CODE_SETALL = 2'd3;

  // targets refused while locked: control, configuration, match
  localparam logic [NUM_TGT-1:0] PROT_MASK = 7'b0001110;
endpackage

// File: rtl/cwg_lock_state.sv
module cwg_lock_state
  import cwg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_wr,
  input  logic [1:0] code,
  output logic [1:0] lock_bits,
  output logic       locked
);
  logic [1:0] bits_nxt;

  always_comb begin
    bits_nxt = lock_bits;
    if (lock_wr) begin
      case (code)
        CODE_SETALL: bits_nxt = 2'b11;
        CODE_CLR0:   bits_nxt = {lock_bits[1], 1'b0};
        CODE_CLR1:   bits_nxt = {1'b0, lock_bits[0]};
        default:     bits_nxt = lock_bits;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_bits <= 2'b00;
      locked    <= 1'b0;
    end else begin
      lock_bits <= bits_nxt;
      locked    <= |bits_nxt;
    end
  end

  assert_set_both_R2: assert property (@(posedge clk) disable iff (rst)
    lock_wr && code == CODE_SETALL |=> lock_bits == 2'b11);
  assert_clr0_R3: assert property (@(posedge clk) disable iff (rst)
    lock_wr && code == CODE_CLR0 |=> !lock_bits[0] && lock_bits[1] == $past(lock_bits[1]));
  assert_clr1_R4: assert property (@(posedge clk) disable iff (rst)
    lock_wr && code == CODE_CLR1 |=> !lock_bits[1] && lock_bits[0] == $past(lock_bits[0]));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(lock_wr && code != CODE_HOLD) |=> $stable(lock_bits));
endmodule

// File: rtl/cwg_write_gate.sv
module cwg_write_gate
  import cwg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [TGT_W-1:0]   wr_target,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               locked,
  output logic [NUM_TGT-1:0] out_we,
  output logic [DATA_W-1:0]  out_data
);
  logic [NUM_TGT-1:0] pass;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    if (i == int'(TGT_LOCK)) begin : g_lock
      assign pass[i] = 1'b0;
    end else if (PROT_MASK[i]) begin : g_prot
      assign pass[i] = wr_valid && (wr_target == TGT_W'(i)) && !locked;
    end else begin : g_open
      assign pass[i] = wr_valid && (wr_target == TGT_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_we   <= '0;
      out_data <= '0;
    end else begin
      out_we <= pass;
      if (|pass) out_data <= wr_data;
    end
  end

  assert_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    wr_valid && locked && (wr_target == TGT_CTRL || wr_target == TGT_CFG ||
    wr_target == TGT_MATCH) |=> out_we == '0);
  assert_irq_open_R8: assert property (@(posedge clk) disable iff (rst)
    wr_valid && (wr_target == TGT_IRQ || wr_target == TGT_ISET || wr_target == TGT_IMASK)
    |=> $onehot0(out_we) && $countones(out_we) == 1);
  assert_pass_R9: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !locked && wr_target == TGT_MATCH
    |=> out_we[TGT_MATCH] && out_data == $past(wr_data));
  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_valid || wr_target == TGT_LOCK || wr_target == 3'd7 |=> out_we == '0);
endmodule

// File: rtl/cfg_write_guard.sv
module cfg_write_guard
  import cwg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [TGT_W-1:0]   wr_target,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [1:0]         lock_bits,
  output logic               locked,
  output logic [NUM_TGT-1:0] out_we,
  output logic [DATA_W-1:0]  out_data
);
  logic lock_wr;
  assign lock_wr = wr_valid && (wr_target == TGT_LOCK);

  cwg_lock_state u_state (
    .clk       (clk),
    .rst       (rst),
    .lock_wr   (lock_wr),
    .code      (wr_data[1:0]),
    .lock_bits (lock_bits),
    .locked    (locked)
  );

  cwg_write_gate #(.DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .wr_target (wr_target),
    .wr_data   (wr_data),
    .locked    (locked),
    .out_we    (out_we),
    .out_data  (out_data)
  );

  assert_status_R6: assert property (@(posedge clk) disable iff (rst)
    locked == (lock_bits != 2'b00));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> lock_bits == 2'b00 && !locked && out_we == '0);
endmodule

// File: tb/cfg_write_guard_tb.sv
module cfg_write_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [2:0]    wr_target = 3'd0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    lock_bits;
  logic          locked;
  logic [6:0]    out_we;
  logic [DW-1:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] m_bits = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_write_guard #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_target(wr_target),
    .wr_data(wr_data), .lock_bits(lock_bits), .locked(locked),
    .out_we(out_we), .out_data(out_data));

  function automatic logic [1:0] next_bits(logic [1:0] b, logic v, logic [2:0] t, logic [1:0] c);
    if (!v || t != 3'd0) return b;
    case (c)
      2'd3: return 2'b11;
      2'd1: return {b[1], 1'b0};
      2'd2: return {1'b0, b[0]};
      default: return b;
    endcase
  endfunction

  function automatic logic [6:0] exp_we(logic [1:0] b, logic v, logic [2:0] t);
    if (!v || t == 3'd0 || t == 3'd7) return 7'd0;
    if (t <= 3'd3 && b != 2'b00) return 7'd0;
    return 7'(1 << t);
  endfunction

  function automatic string bits_tag(logic v, logic [2:0] t, logic [1:0] c);
    if (!v || t != 3'd0 || c == 2'd0) return "R5";
    if (c == 2'd3) return "R2";
    if (c == 2'd1) return "R3";
    return "R4";
  endfunction

  function automatic string we_tag(logic [1:0] b, logic v, logic [2:0] t);
    if (!v || t == 3'd0 || t == 3'd7) return "R10";
    if (t >= 3'd4) return "R8";
    if (b != 2'b00) return "R7";
    return "R9";
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one access at negedge, compare one cycle later at negedge
  task automatic step(logic v, logic [2:0] t, logic [DW-1:0] d);
    logic [1:0] nb;
    logic [6:0] ew;
    string tb_t, tw_t;
    nb = next_bits(m_bits, v, t, d[1:0]);
    ew = exp_we(m_bits, v, t);
    tb_t = bits_tag(v, t, d[1:0]);
    tw_t = we_tag(m_bits, v, t);
    wr_valid = v; wr_target = t; wr_data = d;
    @(negedge clk);
    m_bits = nb;
    check(tb_t, lock_bits, nb);
    check("R6", locked, |nb);
    check(tw_t, out_we, ew);
    if (ew != 0) check("R9", out_data, d);
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", lock_bits, 0);
    check("R1", locked, 0);
    check("R1", out_we, 0);

    // R2 then R11: clear bit1 first, interleaved accesses
    step(1, 3'd0, 32'h3);
    step(1, 3'd1, 32'hA5A5_0001);        // R7 blocked
    step(1, 3'd0, 32'h2);                // clear bit 1
    step(1, 3'd4, 32'h0000_00F0);        // R8 interleaved
    step(1, 3'd2, 32'h1111_2222);        // still locked -> blocked
    check("R11", locked, 1);
    step(1, 3'd0, 32'h2);                // repeated clear, idempotent
    step(1, 3'd0, 32'h1);                // clear bit 0
    check("R11", locked, 0);
    step(1, 3'd3, 32'hDEAD_BEEF);        // R9 passes
    // reverse order
    step(1, 3'd0, 32'h3);
    step(1, 3'd0, 32'h1);
    step(1, 3'd6, 32'h5);
    step(1, 3'd3, 32'h77);               // blocked, bit1 still set
    step(1, 3'd0, 32'h0);                // R5 hold
    step(1, 3'd0, 32'h2);
    check("R11", lock_bits, 0);
    // R12: lock and protected write back to back
    step(1, 3'd0, 32'h3);
    step(1, 3'd1, 32'h9);                // blocked by state set on previous edge
    step(1, 3'd7, 32'h1);                // R10 unused target
    step(1, 3'd0, 32'h1);
    step(1, 3'd0, 32'h2);
    step(1, 3'd1, 32'h42);               // R12: lock cleared by prior edge -> passes
    step(0, 3'd2, 32'h1);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] t;
      logic [DW-1:0] d;
      t = 3'($urandom_range(0, 7));
      d = $urandom;
      step(1'($urandom_range(0, 7) != 0), t, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule